// File: doc/BRIEF.md
# Serial Flash Custom Command Engine

This block issues one custom command to a serial flash device over a single-bit SPI link. A command frame carries an opcode byte followed by up to eight payload bytes. The bytes are shifted out most-significant bit first on `io0` while `io1` is sampled. Every byte clocked in after the opcode is written back into two 32-bit read words. Two optional prefixes can run ahead of the command frame. The first repeatedly reads the device status register until its busy bit is clear. The second sends a write-enable command in its own chip-select frame.

The host sets the command fields and pulses `start` while the engine is idle. The engine captures the fields, runs the prefix frames and the command frame with a chip-select gap after each one, and then pulses `ready`. The read words are valid from that cycle. The serial clock divider and the idle clock polarity (SPI mode 0 or 3) are set by the host. The two spare data lines are held high.

Top module: `qspi_cinstr_engine`

## Requirements
- R1: After reset `csn` is 1, `sck` is 0, `busy` and `ready` are 0, both read words are zero, and `io2`/`io3` are 1.
- R2: A start accepted at a clock edge pulls `csn` low in the following cycle. Each SCK half period lasts `sck_div`+1 clocks, each bit lasts 2×(`sck_div`+1) clocks, and `sck` is low in the first half of each bit.
- R3: Bytes go out MSB first on `io0`. `io0` changes only at the start of a bit (SCK falling edge or frame start) and holds through the high half. `io1` is sampled where `sck` rises.
- R4: `frame_len` is the total byte count of the command frame including the opcode. A value of 0 is treated as 1 and values above 9 are treated as 9.
- R5: Payload byte i (0..3) is taken from `wdata0[8i+7:8i]`. Payload byte i (4..7) is taken from `wdata1[8(i-4)+7:8(i-4)]`.
- R6: The byte received during frame position k+1 lands at the position where R5 takes payload byte k, in `rdata0`/`rdata1`. Positions not received in this command read zero. The read words are cleared when a command is accepted.
- R7: With `wren_en` set, a one-byte frame carrying opcode 0x06 is sent before the command frame.
- R8: With `wait_en` set, two-byte status frames (0x05 then 0x00) are sent first. They repeat while bit 0 of the second received byte is 1, and end on the first frame where it is 0. Other bits are ignored. This happens before any write-enable frame.
- R9: After every frame `csn` stays high for 2×(`sck_div`+1) clocks with `sck` at its idle level.
- R10: `ready` pulses for exactly one cycle, the cycle after the last gap. `busy` is low from that cycle on.
- R11: A `mode_set` pulse while idle with `mode_req`=0 makes the idle `sck` level 0, and with `mode_req`=3 makes it 1. Values 1 and 2, and any `mode_set` while busy, leave the level unchanged.
- R12: A `start` pulse while busy is ignored, and the running command's waveform is unchanged.
- R13: `io2` and `io3` are driven high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| opcode | input | 8 | Command opcode |
| frame_len | input | 4 | Total frame bytes including opcode |
| wren_en | input | 1 | Send write-enable frame first |
| wait_en | input | 1 | Poll status until not busy first |
| sck_div | input | DIV_W | SCK half period minus one, in clocks |
| mode_set | input | 1 | Apply `mode_req` |
| mode_req | input | 2 | Requested SPI mode (0 or 3 accepted) |
| wdata0 | input | 32 | Payload bytes 0..3 |
| wdata1 | input | 32 | Payload bytes 4..7 |
| rdata0 | output | 32 | Received bytes 0..3 |
| rdata1 | output | 32 | Received bytes 4..7 |
| busy | output | 1 | Command in progress |
| ready | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock |
| csn | output | 1 | Chip select, active low |
| io0 | output | 1 | Serial data out |
| io1 | input | 1 | Serial data in |
| io2 | output | 1 | Spare line, held high |
| io3 | output | 1 | Spare line, held high |

## Verification
The first frame cycle follows the `start` sampling edge by one clock. Every bit then spans 2×(`sck_div`+1) clocks and every gap the same. The `ready` pulse and the read words appear in the single cycle after the final gap, and a mode change shows on idle `sck` one cycle after its strobe. The bench turns each command into a queue of expected per-cycle pin values and compares them on every falling clock edge. A responder feeds `io1` from the rising `sck` edges, so poll counts and read bytes are known ahead of time.

// File: rtl/qci_pkg.sv
`timescale 1ns/1ps
package qci_pkg;
  localparam int PAY_BYTES = 8;
  localparam int PAY_W     = PAY_BYTES * 8;
  localparam int IDX_W     = $clog2(PAY_BYTES);
  localparam int LEN_W     = 4;
  localparam int MAX_LEN   = PAY_BYTES + 1;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_STATUS = 8'h05;
  localparam logic [7:0] POLL_FILL  = 8'h00;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} st_t;
  typedef enum logic [1:0] {PH_POLL, PH_WREN, PH_MAIN} ph_t;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (l == '0) return LEN_W'(1);
    if (l > LEN_W'(MAX_LEN)) return LEN_W'(MAX_LEN);
    return l;
  endfunction

  function automatic logic [LEN_W-1:0] phase_len(input ph_t ph, input logic [LEN_W-1:0] l);
    case (ph)
      PH_POLL: return LEN_W'(2);
      PH_WREN: return LEN_W'(1);
      default: return l;
    endcase
  endfunction

  function automatic logic [7:0] frame_byte(input ph_t ph, input logic [LEN_W-1:0] idx,
                                            input logic [7:0] op, input logic [PAY_W-1:0] pay);
    logic [LEN_W-1:0] k;
    k = idx - LEN_W'(1);
    case (ph)
      PH_POLL: return (idx == '0) ? OPC_STATUS : POLL_FILL;
      PH_WREN: return OPC_WREN;
      default: return (idx == '0) ? op : pay[{k[IDX_W-1:0], 3'b000} +: 8];
    endcase
  endfunction
endpackage

// File: rtl/qci_rst_sync.sv
`timescale 1ns/1ps
module qci_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/qci_halfbit.sv
`timescale 1ns/1ps
module qci_halfbit #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             half
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             half_q, half_d;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    if (clr) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (en) begin
      if (cnt_q == div) begin
        cnt_d  = '0;
        half_d = ~half_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  assign tick = en & ~clr & (cnt_q == div);
  assign half = half_q;

  // R2
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (cnt_q <= div));
endmodule

// File: rtl/qci_shift.sv
`timescale 1ns/1ps
module qci_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         advance,
  input  logic         sample,
  input  logic         sdi,
  output logic         sdo,
  output logic [W-1:0] rx,
  output logic         last
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tx_d  = tx_q;
    cnt_d = cnt_q;
    rx_d  = rx_q;
    if (load) begin
      tx_d  = load_val;
      cnt_d = '0;
    end else if (advance) begin
      tx_d  = {tx_q[W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
    end
    if (sample) rx_d = {rx_q[W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      cnt_q <= '0;
      rx_q  <= '0;
    end else begin
      tx_q  <= tx_d;
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
    end
  end

  assign sdo  = tx_q[W-1];
  assign rx   = rx_q;
  assign last = (cnt_q == CW'(W-1));
endmodule

// File: rtl/qspi_cinstr_engine.sv
`timescale 1ns/1ps
module qspi_cinstr_engine
  import qci_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [3:0]       frame_len,
  input  logic             wren_en,
  input  logic             wait_en,
  input  logic [DIV_W-1:0] sck_div,
  input  logic             mode_set,
  input  logic [1:0]       mode_req,
  input  logic [31:0]      wdata0,
  input  logic [31:0]      wdata1,
  output logic [31:0]      rdata0,
  output logic [31:0]      rdata1,
  output logic             busy,
  output logic             ready,
  output logic             sck,
  output logic             csn,
  output logic             io0,
  input  logic             io1,
  output logic             io2,
  output logic             io3
);
  logic rst_ns;
  qci_rst_sync u_rst (.clk(clk), .rst_n_a(rst_n), .rst_n_o(rst_ns));

  st_t              st_q, st_d;
  ph_t              ph_q, ph_d, nph;
  logic [LEN_W-1:0] idx_q, idx_d, len_q, len_d, kpos;
  logic [7:0]       op_q, op_d;
  logic [PAY_W-1:0] pay_q, pay_d, rd_q, rd_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wren_q, wren_d, wait_q, wait_d, wip_q, wip_d;
  logic             cpol_q, cpol_d, ready_q, ready_d;

  logic       in_frame, in_gap, tick, half, rise, fall;
  logic       ld, adv, last;
  logic [7:0] ld_val, rx;

  assign in_frame = (st_q == ST_FRAME);
  assign in_gap   = (st_q == ST_GAP);

  qci_halfbit #(.DIV_W(DIV_W)) u_half (
    .clk(clk), .rst_n(rst_ns), .clr(st_q == ST_IDLE), .en(in_frame | in_gap),
    .div(div_q), .tick(tick), .half(half)
  );

  assign rise = tick & ~half;
  assign fall = tick & half;

  qci_shift #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_ns), .load(ld), .load_val(ld_val), .advance(adv),
    .sample(in_frame & rise), .sdi(io1), .sdo(io0_raw), .rx(rx), .last(last)
  );
  logic io0_raw;

  always_comb begin
    st_d = st_q;   ph_d = ph_q;   idx_d = idx_q; len_d = len_q;
    op_d = op_q;   pay_d = pay_q; rd_d = rd_q;   div_d = div_q;
    wren_d = wren_q; wait_d = wait_q; wip_d = wip_q; cpol_d = cpol_q;
    ready_d = 1'b0; ld = 1'b0; ld_val = 8'h00; adv = 1'b0; nph = PH_MAIN;
    kpos = idx_q - LEN_W'(1);
    case (st_q)
      ST_IDLE: begin
        if (mode_set && (mode_req == 2'b00 || mode_req == 2'b11)) cpol_d = mode_req[0];
        if (start) begin
          nph    = wait_en ? PH_POLL : (wren_en ? PH_WREN : PH_MAIN);
          st_d   = ST_FRAME;  ph_d = nph;  idx_d = '0;
          op_d   = opcode;    len_d = clamp_len(frame_len);
          pay_d  = {wdata1, wdata0};
          div_d  = sck_div;   wren_d = wren_en; wait_d = wait_en;
          rd_d   = '0;
          ld     = 1'b1;
          ld_val = frame_byte(nph, '0, opcode, '0);
        end
      end
      ST_FRAME: begin
        if (fall) begin
          if (last) begin
            if (ph_q == PH_MAIN && idx_q != '0) rd_d[{kpos[IDX_W-1:0], 3'b000} +: 8] = rx;
            if (ph_q == PH_POLL && idx_q == LEN_W'(1)) wip_d = rx[0];
            if (idx_q == phase_len(ph_q, len_q) - LEN_W'(1)) begin
              st_d = ST_GAP;
            end else begin
              idx_d  = idx_q + LEN_W'(1);
              ld     = 1'b1;
              ld_val = frame_byte(ph_q, idx_q + LEN_W'(1), op_q, pay_q);
            end
          end else begin
            adv = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (fall) begin
          if (ph_q == PH_MAIN) begin
            st_d    = ST_IDLE;
            ready_d = 1'b1;
          end else begin
            if (ph_q == PH_POLL && wip_q) nph = PH_POLL;
            else if (ph_q == PH_POLL && wren_q) nph = PH_WREN;
            else nph = PH_MAIN;
            st_d   = ST_FRAME; ph_d = nph; idx_d = '0;
            ld     = 1'b1;
            ld_val = frame_byte(nph, '0, op_q, pay_q);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= ST_IDLE; ph_q <= PH_MAIN; idx_q <= '0; len_q <= '0;
      op_q <= '0; pay_q <= '0; rd_q <= '0; div_q <= '0;
      wren_q <= 1'b0; wait_q <= 1'b0; wip_q <= 1'b0; cpol_q <= 1'b0; ready_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; idx_q <= idx_d; len_q <= len_d;
      op_q <= op_d; pay_q <= pay_d; rd_q <= rd_d; div_q <= div_d;
      wren_q <= wren_d; wait_q <= wait_d; wip_q <= wip_d; cpol_q <= cpol_d; ready_q <= ready_d;
    end
  end

  assign csn    = ~in_frame;
  assign sck    = in_frame ? half : cpol_q;
  assign io0    = in_frame & io0_raw;
  assign io2    = 1'b1;
  assign io3    = 1'b1;
  assign busy   = (st_q != ST_IDLE);
  assign ready  = ready_q;
  assign rdata0 = rd_q[31:0];
  assign rdata1 = rd_q[63:32];

  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |=> $stable(op_q));
  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |=> $stable(cpol_q));
  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ready |=> !ready);
  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ready |-> (csn && !busy));
  // R3
  io0_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!csn && sck && $past(!csn && sck)) |-> $stable(io0));
  // R9
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(csn) |=> csn);
endmodule

// File: tb/tb_qspi_cinstr_engine.sv
`timescale 1ns/1ps
module tb_qspi_cinstr_engine;
  logic        clk, rst_n, start, wren_en, wait_en, mode_set, io1;
  logic [7:0]  opcode;
  logic [3:0]  frame_len, sck_div;
  logic [1:0]  mode_req;
  logic [31:0] wdata0, wdata1, rdata0, rdata1;
  logic        busy, ready, sck, csn, io0, io2, io3;

  qspi_cinstr_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .frame_len(frame_len),
    .wren_en(wren_en), .wait_en(wait_en), .sck_div(sck_div), .mode_set(mode_set),
    .mode_req(mode_req), .wdata0(wdata0), .wdata1(wdata1), .rdata0(rdata0),
    .rdata1(rdata1), .busy(busy), .ready(ready), .sck(sck), .csn(csn), .io0(io0),
    .io1(io1), .io2(io2), .io3(io3)
  );

  initial begin clk = 1'b0; forever #2 clk = ~clk; end

  int total = 0, bad = 0;
  bit chk_on = 0, finished = 0;
  logic [4:0]  exp_q[$];   // {csn, sck, io0, busy, ready}
  string       tag_q[$];
  logic [71:0] rsp_q[$];
  logic [63:0] exp_rd;
  logic        m_cpol = 1'b0;

  task automatic chk(input bit ok, input string t, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // per-cycle comparison against the expected queue
  initial begin
    forever begin
      logic [4:0] e;
      string t;
      @(negedge clk);
      if (chk_on) begin
        if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
        else begin e = {1'b1, m_cpol, 1'b0, 1'b0, 1'b0}; t = "R2 R11 idle"; end
        chk(csn === e[4], t, "csn", 64'(csn), 64'(e[4]));
        chk(sck === e[3], t, "sck", 64'(sck), 64'(e[3]));
        if (!e[4]) chk(io0 === e[2], {t, " R3"}, "io0", 64'(io0), 64'(e[2]));
        chk(busy === e[1], t, "busy", 64'(busy), 64'(e[1]));
        chk(ready === e[0], {t, " R10"}, "ready", 64'(ready), 64'(e[0]));
        chk((io2 === 1'b1) && (io3 === 1'b1), "R13", "io2/io3", 64'({io2, io3}), 64'h3);
        if (e[0]) chk({rdata1, rdata0} === exp_rd, {t, " R6"}, "rdata", {rdata1, rdata0}, exp_rd);
      end
    end
  end

  // flash responder: next bit after every rising sck, reload on chip select
  initial begin
    logic pc, ps;
    int bix;
    logic [71:0] cur;
    io1 = 1'b0; pc = 1'b1; ps = 1'b0; cur = '0; bix = 0;
    forever begin
      @(csn or sck);
      if (pc === 1'b1 && csn === 1'b0) begin
        if (rsp_q.size() > 0) cur = rsp_q.pop_front(); else cur = '0;
        bix = 0;
        io1 = cur[71];
      end else if (csn === 1'b0 && sck === 1'b1 && ps === 1'b0) begin
        bix++;
        if (bix < 72) io1 = cur[71-bix];
      end
      pc = csn; ps = sck;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  task automatic push_cyc(input logic c, input logic s, input logic d, input logic b,
                          input logic r, input string t);
    exp_q.push_back({c, s, d, b, r});
    tag_q.push_back(t);
  endtask

  task automatic push_frame(input logic [71:0] fb, input int nb, input int h, input string t);
    for (int by = 0; by < nb; by++)
      for (int bi = 0; bi < 8; bi++)
        for (int c = 0; c < 2*h; c++)
          push_cyc(1'b0, (c >= h), fb[71-8*by-bi], 1'b1, 1'b0, t);
  endtask

  task automatic push_gap(input int h, input string t);
    for (int c = 0; c < 2*h; c++) push_cyc(1'b1, m_cpol, 1'b0, 1'b1, 1'b0, {t, " R9"});
  endtask

  task automatic run_cmd(input logic [7:0] opc, input int len_in, input bit wr, input bit wt,
                         input int dv, input logic [31:0] w0, input logic [31:0] w1,
                         input int nbusy, input logic [63:0] resp, input int inj_at,
                         input string t);
    int L, h;
    logic [71:0] mb;
    L = (len_in == 0) ? 1 : ((len_in > 9) ? 9 : len_in);
    h = dv + 1;
    push_cyc(1'b1, m_cpol, 1'b0, 1'b0, 1'b0, t);
    if (wt) begin
      for (int p = 0; p <= nbusy; p++) begin
        push_frame({8'h05, 8'h00, 56'h0}, 2, h, "R8 status poll");
        push_gap(h, "R8");
        rsp_q.push_back({8'hA5, (p < nbusy) ? 8'h01 : 8'hFE, 56'h0});
      end
    end
    if (wr) begin
      push_frame({8'h06, 64'h0}, 1, h, "R7 write enable");
      push_gap(h, "R7");
      rsp_q.push_back('0);
    end
    mb = '0;
    mb[71:64] = opc;
    for (int i = 0; i < 8; i++)
      mb[63-8*i -: 8] = (i < 4) ? w0[8*i +: 8] : w1[8*(i-4) +: 8];
    push_frame(mb, L, h, {t, " R4 R5"});
    push_gap(h, t);
    push_cyc(1'b1, m_cpol, 1'b0, 1'b0, 1'b1, {t, " done"});
    rsp_q.push_back({8'h5A, resp});
    for (int k = 0; k < 8; k++)
      exp_rd[8*k +: 8] = (k < L-1) ? resp[63-8*k -: 8] : 8'h00;

    @(posedge clk); #1;
    opcode = opc; frame_len = 4'(len_in); wren_en = wr; wait_en = wt;
    sck_div = 4'(dv); wdata0 = w0; wdata1 = w1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (inj_at > 0) begin
      // R12 and R11: start and mode strobes while busy must change nothing
      repeat (inj_at) @(posedge clk);
      #1;
      start = 1'b1; opcode = 8'hEE; wren_en = 1'b1; sck_div = 4'd7;
      mode_set = 1'b1; mode_req = {2{~m_cpol}};
      @(posedge clk); #1;
      start = 1'b0; mode_set = 1'b0;
    end
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] v);
    @(posedge clk); #1;
    mode_set = 1'b1; mode_req = v;
    @(posedge clk); #1;
    mode_set = 1'b0;
    if (v == 2'b00 || v == 2'b11) m_cpol = v[0];
    @(negedge clk);
    chk(sck === m_cpol, "R11 idle level after mode strobe", "sck", 64'(sck), 64'(m_cpol));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = '0; frame_len = '0; wren_en = 1'b0;
    wait_en = 1'b0; sck_div = '0; mode_set = 1'b0; mode_req = '0;
    wdata0 = '0; wdata1 = '0; exp_rd = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(csn === 1'b1, "R1", "csn", 64'(csn), 64'h1);
    chk(sck === 1'b0, "R1", "sck", 64'(sck), 64'h0);
    chk(busy === 1'b0 && ready === 1'b0, "R1", "busy/ready", 64'({busy, ready}), 64'h0);
    chk({rdata1, rdata0} === 64'h0, "R1", "rdata", {rdata1, rdata0}, 64'h0);
    chk(io2 === 1'b1 && io3 === 1'b1, "R1 R13", "io2/io3", 64'({io2, io3}), 64'h3);
    chk_on = 1;

    run_cmd(8'h9F, 4, 0, 0, 0, 32'h0, 32'h0, 0, 64'hC2_20_17_99_88_77_66_55, 0, "R2 R3 R6 read id");
    run_cmd(8'h02, 9, 0, 0, 2, 32'h44332211, 32'h88776655, 0, 64'h0102030405060708, 0, "R5 full payload");
    run_cmd(8'hB7, 1, 0, 0, 1, 32'hDEADBEEF, 32'h0, 0, 64'hFFFFFFFFFFFFFFFF, 0, "R4 opcode only");
    run_cmd(8'h66, 0, 0, 0, 0, 32'h0, 32'h0, 0, 64'h1111111111111111, 0, "R4 zero length");
    run_cmd(8'h3B, 12, 0, 0, 0, 32'hA1B2C3D4, 32'h0F1E2D3C, 0, 64'h8899AABBCCDDEEFF, 0, "R4 over length");
    run_cmd(8'h01, 3, 1, 0, 1, 32'h00000240, 32'h0, 0, 64'h0, 0, "R7 prefixed write");
    run_cmd(8'h20, 4, 1, 1, 1, 32'h00100000, 32'h0, 2, 64'h0, 0, "R8 busy poll");
    run_cmd(8'h05, 2, 0, 1, 0, 32'h0, 32'h0, 0, 64'h7E00000000000000, 0, "R8 already idle");
    set_mode(2'b01);
    set_mode(2'b11);
    run_cmd(8'h0B, 5, 0, 0, 3, 32'h55AA33CC, 32'h0, 0, 64'hFEDCBA9876543210, 0, "R11 mode3 frame");
    set_mode(2'b10);
    run_cmd(8'h6B, 6, 1, 0, 1, 32'h12345678, 32'h9ABCDEF0, 0, 64'h0123456789ABCDEF, 20, "R12 R11 busy strobes");
    set_mode(2'b00);
    run_cmd(8'hAB, 2, 0, 0, 15, 32'h000000C3, 32'h0, 0, 64'h3C00000000000000, 0, "R2 slow clock");
    finish_run();
  end
endmodule